// File: doc/BRIEF.md
# Decimal Add/Subtract Unit

A purely combinational unit for packed decimal operands. Each operand holds `DIGITS` decimal digits, four bits per digit, with the least significant digit in bits [3:0]. A mode input selects the operation. In add mode the unit returns the decimal sum and a carry out of the top digit. In subtract mode it returns the magnitude of the first operand minus the second, together with a sign flag.

Every digit position does a 4-bit binary add and then a decimal correction step. Subtraction takes the nines' complement of each subtrahend digit and adds it to the minuend. A carry out of the top digit means the result is positive. That carry is then fed back in at the bottom digit (end-around carry) and rippled through a second correcting adder chain. If there is no carry out, the result is negative, and each digit of the sum is complemented to nines to give the magnitude.

Operands are assumed to hold valid decimal digits. The unit has no registers.

Top module: `bcd_addsub`

## Requirements
- R1: With `subtract` = 0, `result` equals (A + B) mod 10^DIGITS, `carryOut` is 1 exactly when A + B >= 10^DIGITS, and `negative` is 0.
- R2: For valid decimal operands, every 4-bit digit of `result` lies in 0..9 in both modes.
- R3: With `subtract` = 1 and A > B, `result` equals A - B, and both `negative` and `carryOut` are 0.
- R4: With `subtract` = 1 and A < B, `result` equals B - A, `negative` is 1 and `carryOut` is 0.
- R5: With `subtract` = 1 and A = B, `result` is zero and `negative` is 0.
- R6: A digit whose binary sum exceeds 9, or which carries out of its 4 bits, is corrected by adding 6 and passes a carry to the next digit. For example 9 + 9 gives digit 8 with a carry, and 9999 + 1 in four digits gives 0000 with `carryOut` = 1.
- R7: The end-around carry goes through the same decimal correction, so it ripples across digits that are 9. For example 20 - 10 gives 10, and 1000 - 1 gives 0999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4*DIGITS | First operand (minuend), packed decimal |
| opB | input | 4*DIGITS | Second operand (subtrahend), packed decimal |
| subtract | input | 1 | 0 selects add, 1 selects A minus B |
| result | output | 4*DIGITS | Sum, or magnitude of the difference |
| carryOut | output | 1 | Decimal carry out of the top digit in add mode, 0 in subtract mode |
| negative | output | 1 | Set when the difference is below zero |

## Verification
Two functions can act on the same operand pair. The first is the decimal correction inside a digit. The second is the end-around carry that re-enters at the bottom digit. Both fire when a subtraction such as 20 - 10 first gives a corrected sum whose low digits are 9, and the end-around carry then has to ripple through them with correction again. The bench provokes this overlap in three ways: a full sweep of every single-digit pair in both modes, directed four-digit cases, and random four-digit vectors. Each output is judged against integer arithmetic. Every result digit is also checked to lie in 0..9.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

  typedef logic [3:0] digit_t;

  // strobes that do not depend on the first adder pass
  typedef struct packed {
    logic invertB;
  } pre_strobe_t;

  // strobes decided from the first pass outcome
  typedef struct packed {
    logic endAround;
    logic recomplement;
    logic signNeg;
    logic carryEn;
  } post_strobe_t;

  function automatic logic digitOk(input digit_t d);
    return d <= 4'd9;
  endfunction

endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_addsub_pkg::*;
(
  input  digit_t digA,
  input  digit_t digB,
  input  logic   carryIn,
  output digit_t digSum,
  output logic   carryOutD
);

  logic [4:0] binSum;
  logic       needFix;

  always_comb begin
    binSum    = {1'b0, digA} + {1'b0, digB} + {4'b0, carryIn};
    needFix   = binSum[4] | (binSum[3:0] > 4'd9);
    digSum    = needFix ? (binSum[3:0] + 4'd6) : binSum[3:0];
    carryOutD = needFix;
  end

  always_comb begin
    // R6
    digit_range_chk : assert (!(digitOk(digA) && digitOk(digB)) || digitOk(digSum))
      else $error("corrected digit out of range");
  end

endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 1
) (
  input  logic [4*DIGITS-1:0] opX,
  input  logic [4*DIGITS-1:0] opY,
  input  logic                chainIn,
  output logic [4*DIGITS-1:0] sumOut,
  output logic                chainOut
);

  logic [DIGITS:0] carryChain;

  assign carryChain[0] = chainIn;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    bcd_digit_cell u_cell (
      .digA     (opX[4*d +: 4]),
      .digB     (opY[4*d +: 4]),
      .carryIn  (carryChain[d]),
      .digSum   (sumOut[4*d +: 4]),
      .carryOutD(carryChain[d+1])
    );
  end

  assign chainOut = carryChain[DIGITS];

endmodule

// File: rtl/bcd_addsub_ctrl.sv
module bcd_addsub_ctrl
  import bcd_addsub_pkg::*;
(
  input  logic         subtract,
  input  logic         firstCarry,
  input  logic         allNines,
  output pre_strobe_t  preStb,
  output post_strobe_t postStb
)
;

  always_comb begin
    preStb.invertB       = subtract;
    postStb.endAround    = subtract & firstCarry;
    postStb.recomplement = subtract & ~firstCarry;
    // equal operands give all nines; recomplement is zero, sign stays clear
    postStb.signNeg      = subtract & ~firstCarry & ~allNines;
    postStb.carryEn      = ~subtract;
  end

  always_comb begin
    // R3
    strobe_excl_chk : assert (!(postStb.endAround && postStb.recomplement))
      else $error("end-around and recomplement both active");
  end

endmodule

// File: rtl/bcd_addsub_dp.sv
module bcd_addsub_dp
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 1
) (
  input  logic [4*DIGITS-1:0] opA,
  input  logic [4*DIGITS-1:0] opB,
  input  pre_strobe_t         preStb,
  input  post_strobe_t        postStb,
  output logic                firstCarry,
  output logic                allNines,
  output logic [4*DIGITS-1:0] result
);

  localparam int WIDTH = 4 * DIGITS;

  logic [WIDTH-1:0]  bEff;
  logic [WIDTH-1:0]  pass1Sum;
  logic [WIDTH-1:0]  pass2Sum;
  logic [WIDTH-1:0]  ninesSum;
  logic [DIGITS-1:0] digNine;
  logic              pass2Carry;

  for (genvar d = 0; d < DIGITS; d++) begin : g_lane
    assign bEff[4*d +: 4]     = preStb.invertB ? (4'd9 - opB[4*d +: 4]) : opB[4*d +: 4];
    assign ninesSum[4*d +: 4] = 4'd9 - pass1Sum[4*d +: 4];
    assign digNine[d]         = (pass1Sum[4*d +: 4] == 4'd9);
  end

  bcd_ripple #(.DIGITS(DIGITS)) u_pass1 (
    .opX     (opA),
    .opY     (bEff),
    .chainIn (1'b0),
    .sumOut  (pass1Sum),
    .chainOut(firstCarry)
  );

  bcd_ripple #(.DIGITS(DIGITS)) u_pass2 (
    .opX     (pass1Sum),
    .opY     ({WIDTH{1'b0}}),
    .chainIn (postStb.endAround),
    .sumOut  (pass2Sum),
    .chainOut(pass2Carry)
  );

  assign allNines = &digNine;
  assign result   = postStb.recomplement ? ninesSum : pass2Sum;

  always_comb begin
    // R3
    no_eac_overflow_chk : assert (!(postStb.endAround && pass2Carry))
      else $error("end-around carry overflowed");
  end

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 1
) (
  input  logic [4*DIGITS-1:0] opA,
  input  logic [4*DIGITS-1:0] opB,
  input  logic                subtract,
  output logic [4*DIGITS-1:0] result,
  output logic                carryOut,
  output logic                negative
);

  pre_strobe_t  preStb;
  post_strobe_t postStb;
  logic         firstCarry;
  logic         allNines;

  bcd_addsub_ctrl u_ctrl (
    .subtract  (subtract),
    .firstCarry(firstCarry),
    .allNines  (allNines),
    .preStb    (preStb),
    .postStb   (postStb)
  );

  bcd_addsub_dp #(.DIGITS(DIGITS)) u_dp (
    .opA       (opA),
    .opB       (opB),
    .preStb    (preStb),
    .postStb   (postStb),
    .firstCarry(firstCarry),
    .allNines  (allNines),
    .result    (result)
  );

  assign carryOut = postStb.carryEn & firstCarry;
  assign negative = postStb.signNeg;

  logic inputsValid;
  always_comb begin
    inputsValid = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (!digitOk(opA[4*d +: 4]) || !digitOk(opB[4*d +: 4])) inputsValid = 1'b0;
    end
  end

  always_comb begin
    // R1
    add_sign_clear_chk : assert (subtract || !negative)
      else $error("sign set in add mode");
    // R4
    sub_carry_clear_chk : assert (!subtract || !carryOut)
      else $error("carry set in subtract mode");
    // R5
    zero_sign_chk : assert (!(inputsValid && negative) || (result != '0))
      else $error("negative zero");
  end

endmodule

// File: tb/bcd_addsub_test.sv
module bcd_addsub_test;

  localparam int WIDE = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [3:0]        aN, bN, rN;
  logic              sN, cN, nN;
  logic [4*WIDE-1:0] aW, bW, rW;
  logic              sW, cW, nW;

  bcd_addsub #(.DIGITS(1)) uut (
    .opA(aN), .opB(bN), .subtract(sN),
    .result(rN), .carryOut(cN), .negative(nN)
  );

  bcd_addsub #(.DIGITS(WIDE)) uutWide (
    .opA(aW), .opB(bW), .subtract(sW),
    .result(rW), .carryOut(cW), .negative(nW)
  );

  function automatic logic [4*WIDE-1:0] toBcd(input int v);
    logic [4*WIDE-1:0] r = '0;
    int x = v;
    for (int d = 0; d < WIDE; d++) begin
      r[4*d +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic string tagFor(input int a, input int b, input logic s, input int digits);
    int m = (digits == 1) ? 10 : 10000;
    if (!s) return (a + b >= m) ? "R6" : "R1";
    if (a > b) return "R3";
    if (a < b) return "R4";
    return "R5";
  endfunction

  task automatic runCase(input int a, input int b, input logic s, input int digits, input string tag);
    int m = (digits == 1) ? 10 : 10000;
    int expR;
    logic expC, expN;
    logic [4*WIDE-1:0] got;
    logic gotC, gotN;
    if (!s) begin
      expR = (a + b) % m; expC = (a + b) >= m; expN = 1'b0;
    end else if (a >= b) begin
      expR = a - b; expC = 1'b0; expN = 1'b0;
    end else begin
      expR = b - a; expC = 1'b0; expN = 1'b1;
    end
    @(negedge clk);
    if (digits == 1) begin
      aN = 4'(a); bN = 4'(b); sN = s;
    end else begin
      aW = toBcd(a); bW = toBcd(b); sW = s;
    end
    @(posedge clk);
    #1;
    if (digits == 1) begin got = {12'b0, rN}; gotC = cN; gotN = nN; end
    else begin got = rW; gotC = cW; gotN = nW; end
    checks++;
    if (got != toBcd(expR) || gotC != expC || gotN != expN) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d sub=%0b: got r=%h c=%0b n=%0b expected r=%h c=%0b n=%0b",
               tag, a, b, s, got, gotC, gotN, toBcd(expR), expC, expN);
    end
    for (int d = 0; d < digits; d++) begin
      checks++;
      if (got[4*d +: 4] > 4'd9) begin
        errors++;
        $display("FAIL R2 digit %0d: got %0d expected <=9", d, got[4*d +: 4]);
      end
    end
  endtask

  initial begin
    aN = '0; bN = '0; sN = 1'b0;
    aW = '0; bW = '0; sW = 1'b0;
    // idle state with zero operands: R1
    runCase(0, 0, 1'b0, 1, "R1");
    runCase(0, 0, 1'b0, WIDE, "R1");
    // exhaustive single-digit sweep, both modes
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 10; a++)
        for (int b = 0; b < 10; b++)
          runCase(a, b, 1'(s), 1, tagFor(a, b, 1'(s), 1));
    // directed wide cases
    runCase(9999, 1, 1'b0, WIDE, "R6");
    runCase(9, 9, 1'b0, WIDE, "R6");
    runCase(20, 10, 1'b1, WIDE, "R7");
    runCase(1000, 1, 1'b1, WIDE, "R7");
    runCase(5000, 4000, 1'b1, WIDE, "R7");
    runCase(1, 1000, 1'b1, WIDE, "R4");
    runCase(4321, 4321, 1'b1, WIDE, "R5");
    runCase(9999, 9999, 1'b1, WIDE, "R5");
    runCase(0, 9999, 1'b1, WIDE, "R4");
    runCase(9999, 0, 1'b1, WIDE, "R3");
    // random wide vectors
    for (int i = 0; i < 300; i++) begin
      int a = int'($urandom % 10000);
      int b = int'($urandom % 10000);
      logic s = 1'($urandom % 2);
      runCase(a, b, s, WIDE, tagFor(a, b, s, WIDE));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule